// File: doc/BRIEF.md
# Shared Memory Port Sequencer and Pipeline Stepper

This block arbitrates a single memory port among three kinds of access, namely instruction fetch, DMA transfer and execute-stage load/store. It also decides when the three-stage pipeline (fetch, decode, execute) may advance. Every pipeline step begins with a mandatory fetch access. An inserted DMA access may follow it, and then a load/store access if the instruction in execute needs one. The step ends when the last of these accesses completes. The sequencer changes state only on the memory ready input. A slow memory therefore stretches the current access without any other effect.

The block also squashes the two instructions that sit behind a jump or taken branch. Squashed instructions cannot write back and cannot issue a load/store. The block holds pending requests for DMA and interrupts. An interrupt is honoured by telling the fetch path to latch a hardwired call-to-handler instruction. The block then flags the following step so that the return-address register is not updated. The decoder supplies the execute-stage attributes: load/store, store, byte, and jump/taken branch.

Top module: `mem_pipe_ctrl`

## Requirements
- R1: After reset the current access is a fetch (`fetch_cyc`=1, `dma_cyc`=`ldst_cyc`=0), both annul flags and `ret_hold` are low, and no DMA or interrupt request is pending.
- R2: While `mem_rdy` is low, the access type does not change and `pipe_en` stays low.
- R3: `addr_en` equals `mem_rdy` in every cycle.
- R4: A DMA request is remembered until it is served. A completed fetch is followed by exactly one DMA access if a request is pending or present in that cycle. A request seen in the cycle a DMA access completes is consumed by that access.
- R5: Accesses within a step run in the order fetch, DMA, load/store. A load/store access follows when `ex_ldst`=1 and `ex_annul`=0.
- R6: `pipe_en` is high only in the cycle where the last access of the step completes with `mem_rdy` high.
- R7: At a step end with `ex_jump`=1 and `ex_annul`=0, `dc_annul` and `ex_annul` are set. The next step keeps `ex_annul` high, and the step after that clears it, so a taken transfer occupies three steps. An annulled instruction never causes a load/store access.
- R8: The next-access strobes are as follows. `nx_dbus`=1 exactly when the next access is load/store. `nx_read`=0 only when it is a store (`ex_store`=1). `nx_word`=0 only when it is a byte access (`ex_byte`=1).
- R9: `ins_int` pulses at a step end when an interrupt is pending or requested. It does not pulse if that step takes a jump, or if `ret_hold` is high. The pending interrupt is cleared by the insertion.
- R10: `ret_hold` is high for exactly the step after an insertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdy | input | 1 | Current memory access completes this cycle |
| dma_req | input | 1 | DMA transfer requested |
| irq_req | input | 1 | Interrupt requested |
| ex_ldst | input | 1 | Execute-stage instruction is a load or store |
| ex_store | input | 1 | Execute-stage access is a store |
| ex_byte | input | 1 | Execute-stage access is a byte |
| ex_jump | input | 1 | Execute-stage instruction is a jump or taken branch |
| pipe_en | output | 1 | Advance the pipeline registers |
| fetch_cyc | output | 1 | Current access is an instruction fetch |
| dma_cyc | output | 1 | Current access is a DMA transfer |
| ldst_cyc | output | 1 | Current access is a load/store |
| addr_en | output | 1 | Next address and strobes valid; start next access |
| nx_read | output | 1 | Next access is a read |
| nx_word | output | 1 | Next access is 16-bit |
| nx_dbus | output | 1 | Next access uses the data bus (load/store) |
| dc_annul | output | 1 | Decode-stage instruction is squashed |
| ex_annul | output | 1 | Execute-stage instruction is squashed |
| ins_int | output | 1 | Latch the handler-call instruction at this step end |
| ret_hold | output | 1 | Inhibit return-address capture this step |

## Verification
The bench sweeps input patterns from a pseudo-random generator. Stalls are biased to be frequent, and a bench-side step model supplies the expected values. Several corner cases get particular attention. One is a DMA request arriving in the very cycle its access completes: a wrong design would insert a second DMA cycle. Another is a load/store in the jump shadow: a design that fails to consult `ex_annul` would issue a memory access for a squashed store. Others are an interrupt that coincides with a taken jump, where a wrong design inserts a call that is then annulled and lost, and back-to-back interrupts, which a wrong design would insert while `ret_hold` is still high. A stall in any state is also compared, because a design that pulses `pipe_en` on a not-ready cycle would double-step the pipeline.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_DMA   = 2'd1,
      ACC_LDST  = 2'd2
   } acc_e;
   localparam int ACC_KINDS = 3;
endpackage

// File: rtl/mpc_seq.sv
module mpc_seq
   import mpc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rdy,
   input  logic dma_want,
   input  logic ldst_want,
   input  logic ex_store,
   input  logic ex_byte,
   output acc_e cur,
   output logic step_done,
   output logic dma_done,
   output logic nx_read,
   output logic nx_word,
   output logic nx_dbus
);
   acc_e succ;
   logic last;

   always_comb begin
      succ = ACC_FETCH;
      last = 1'b1;
      unique case (cur)
         ACC_FETCH: begin
            if (dma_want) begin
               succ = ACC_DMA;
               last = 1'b0;
            end else if (ldst_want) begin
               succ = ACC_LDST;
               last = 1'b0;
            end
         end
         ACC_DMA: begin
            if (ldst_want) begin
               succ = ACC_LDST;
               last = 1'b0;
            end
         end
         default: begin
            succ = ACC_FETCH;
            last = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cur <= ACC_FETCH;
      else if (rdy)
         cur <= succ;
   end

   assign step_done = rdy & last;
   assign dma_done  = rdy & (cur == ACC_DMA);
   assign nx_dbus   = (succ == ACC_LDST);
   assign nx_read   = ~(nx_dbus & ex_store);
   assign nx_word   = ~(nx_dbus & ex_byte);
endmodule

// File: rtl/mpc_pend.sv
module mpc_pend #(
   parameter int HAS_DMA = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dma_req,
   input  logic dma_done,
   input  logic irq_req,
   input  logic int_taken,
   output logic dma_want,
   output logic int_want
);
   logic int_pend;

   generate
      if (HAS_DMA != 0) begin : g_dma
         logic dma_pend;
         always_ff @(posedge clk) begin
            if (!rst_n)
               dma_pend <= 1'b0;
            else if (dma_done)
               dma_pend <= 1'b0;
            else if (dma_req)
               dma_pend <= 1'b1;
         end
         assign dma_want = dma_pend | dma_req;
      end else begin : g_nodma
         assign dma_want = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         int_pend <= 1'b0;
      else if (int_taken)
         int_pend <= 1'b0;
      else if (irq_req)
         int_pend <= 1'b1;
   end

   assign int_want = int_pend | irq_req;
endmodule

// File: rtl/mpc_annul.sv
module mpc_annul (
   input  logic clk,
   input  logic rst_n,
   input  logic pipe_en,
   input  logic ex_jump,
   input  logic int_want,
   output logic dc_annul,
   output logic ex_annul,
   output logic ins_int,
   output logic ret_hold
);
   logic take;

   assign take    = ex_jump & ~ex_annul;
   assign ins_int = pipe_en & int_want & ~take & ~ret_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dc_annul <= 1'b0;
         ex_annul <= 1'b0;
         ret_hold <= 1'b0;
      end else if (pipe_en) begin
         dc_annul <= take;
         ex_annul <= take | dc_annul;
         ret_hold <= ins_int;
      end
   end
endmodule

// File: rtl/mem_pipe_ctrl.sv
module mem_pipe_ctrl
   import mpc_pkg::*;
#(
   parameter int HAS_DMA = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mem_rdy,
   input  logic dma_req,
   input  logic irq_req,
   input  logic ex_ldst,
   input  logic ex_store,
   input  logic ex_byte,
   input  logic ex_jump,
   output logic pipe_en,
   output logic fetch_cyc,
   output logic dma_cyc,
   output logic ldst_cyc,
   output logic addr_en,
   output logic nx_read,
   output logic nx_word,
   output logic nx_dbus,
   output logic dc_annul,
   output logic ex_annul,
   output logic ins_int,
   output logic ret_hold
);
   generate
      if (HAS_DMA != 0 && HAS_DMA != 1) begin : g_bad_cfg
         $error("HAS_DMA must be 0 or 1");
      end
   endgenerate

   acc_e cur;
   logic dma_want, int_want, dma_done, step_done, ldst_want;

   assign ldst_want = ex_ldst & ~ex_annul;

   mpc_seq u_seq (
      .clk(clk), .rst_n(rst_n), .rdy(mem_rdy),
      .dma_want(dma_want), .ldst_want(ldst_want),
      .ex_store(ex_store), .ex_byte(ex_byte),
      .cur(cur), .step_done(step_done), .dma_done(dma_done),
      .nx_read(nx_read), .nx_word(nx_word), .nx_dbus(nx_dbus)
   );

   mpc_pend #(.HAS_DMA(HAS_DMA)) u_pend (
      .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_done(dma_done),
      .irq_req(irq_req), .int_taken(ins_int),
      .dma_want(dma_want), .int_want(int_want)
   );

   mpc_annul u_annul (
      .clk(clk), .rst_n(rst_n), .pipe_en(step_done), .ex_jump(ex_jump),
      .int_want(int_want), .dc_annul(dc_annul), .ex_annul(ex_annul),
      .ins_int(ins_int), .ret_hold(ret_hold)
   );

   assign pipe_en   = step_done;
   assign addr_en   = mem_rdy;
   assign fetch_cyc = (cur == ACC_FETCH);
   assign dma_cyc   = (cur == ACC_DMA);
   assign ldst_cyc  = (cur == ACC_LDST);
endmodule

// File: rtl/mem_pipe_ctrl_chk.sv
module mem_pipe_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic mem_rdy,
   input logic pipe_en,
   input logic fetch_cyc,
   input logic dma_cyc,
   input logic ldst_cyc,
   input logic addr_en,
   input logic nx_read,
   input logic nx_word,
   input logic nx_dbus,
   input logic ex_annul,
   input logic ins_int,
   input logic ret_hold
);
   assert_addr_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_en == mem_rdy);

   assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rdy |=> $stable({fetch_cyc, dma_cyc, ldst_cyc}));

   assert_stall_no_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rdy |-> !pipe_en);

   assert_one_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({fetch_cyc, dma_cyc, ldst_cyc}) == 1);

   assert_step_returns_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_en |=> fetch_cyc);

   assert_single_dma_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_cyc && mem_rdy) |=> !dma_cyc);

   assert_no_annulled_ldst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ldst_cyc |-> !ex_annul);

   assert_store_on_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!nx_read || !nx_word) |-> nx_dbus);

   assert_insert_at_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ins_int |-> (pipe_en && !ret_hold));

   assert_hold_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ins_int |=> ret_hold);
endmodule

bind mem_pipe_ctrl mem_pipe_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .pipe_en(pipe_en),
   .fetch_cyc(fetch_cyc), .dma_cyc(dma_cyc), .ldst_cyc(ldst_cyc),
   .addr_en(addr_en), .nx_read(nx_read), .nx_word(nx_word),
   .nx_dbus(nx_dbus), .ex_annul(ex_annul), .ins_int(ins_int),
   .ret_hold(ret_hold)
);

// File: tb/mem_pipe_ctrl_test.sv
module mem_pipe_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mem_rdy = 1'b0, dma_req = 1'b0, irq_req = 1'b0;
   logic ex_ldst = 1'b0, ex_store = 1'b0, ex_byte = 1'b0, ex_jump = 1'b0;
   logic pipe_en, fetch_cyc, dma_cyc, ldst_cyc, addr_en;
   logic nx_read, nx_word, nx_dbus, dc_annul, ex_annul, ins_int, ret_hold;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   mem_pipe_ctrl uut (
      .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .dma_req(dma_req),
      .irq_req(irq_req), .ex_ldst(ex_ldst), .ex_store(ex_store),
      .ex_byte(ex_byte), .ex_jump(ex_jump), .pipe_en(pipe_en),
      .fetch_cyc(fetch_cyc), .dma_cyc(dma_cyc), .ldst_cyc(ldst_cyc),
      .addr_en(addr_en), .nx_read(nx_read), .nx_word(nx_word),
      .nx_dbus(nx_dbus), .dc_annul(dc_annul), .ex_annul(ex_annul),
      .ins_int(ins_int), .ret_hold(ret_hold)
   );

   task automatic check(input string req, input string what,
                        input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // bench-side step model; access codes 0 fetch, 1 dma, 2 load/store
   int  m_acc;
   bit  m_dmap, m_intp, m_dca, m_exa, m_hold;

   initial begin
      #2000000;
      if (!finished) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      // R1: reset state, with requests present during reset
      repeat (3) begin
         @(negedge clk);
         mem_rdy = 1'b1; dma_req = 1'b1; irq_req = 1'b1;
      end
      @(negedge clk);
      mem_rdy = 1'b0; dma_req = 1'b0; irq_req = 1'b0;
      rst_n = 1'b1;
      #5;
      check("R1", "fetch_cyc", fetch_cyc, 1'b1);
      check("R1", "dma_cyc", dma_cyc, 1'b0);
      check("R1", "ldst_cyc", ldst_cyc, 1'b0);
      check("R1", "dc_annul", dc_annul, 1'b0);
      check("R1", "ex_annul", ex_annul, 1'b0);
      check("R1", "ret_hold", ret_hold, 1'b0);
      check("R1", "no pending int", ins_int, 1'b0);
      m_acc = 0; m_dmap = 0; m_intp = 0; m_dca = 0; m_exa = 0; m_hold = 0;
      // R1: first completed fetch with no requests ends the step (nothing pending)
      mem_rdy = 1'b1;
      #1;
      check("R1", "no pending dma", pipe_en, 1'b1);
      check("R1", "no pending int step", ins_int, 1'b0);
      @(posedge clk);

      for (int cyc = 0; cyc < 6000; cyc++) begin
         bit ldw, dmw, last, pe, take, ins;
         int succ, nacc;
         @(negedge clk);
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         mem_rdy  = (lf[1:0] != 2'b00);
         dma_req  = (lf[4:2] == 3'b000);
         irq_req  = (lf[8:5] == 4'b0000) || (cyc[9:4] == 6'd3);
         ex_ldst  = lf[9] | lf[10];
         ex_store = lf[11];
         ex_byte  = lf[12];
         ex_jump  = (lf[14:13] == 2'b11);
         #5;
         ldw = ex_ldst && !m_exa;
         dmw = m_dmap || dma_req;
         if (m_acc == 0) begin
            succ = dmw ? 1 : (ldw ? 2 : 0);
            last = !dmw && !ldw;
         end else if (m_acc == 1) begin
            succ = ldw ? 2 : 0;
            last = !ldw;
         end else begin
            succ = 0;
            last = 1'b1;
         end
         pe   = mem_rdy && last;
         take = ex_jump && !m_exa;
         ins  = pe && (m_intp || irq_req) && !take && !m_hold;
         check("R5", "fetch_cyc", fetch_cyc, m_acc == 0);
         check("R4", "dma_cyc", dma_cyc, m_acc == 1);
         check("R5", "ldst_cyc", ldst_cyc, m_acc == 2);
         check("R2/R6", "pipe_en", pipe_en, pe);
         check("R3", "addr_en", addr_en, mem_rdy);
         check("R8", "nx_dbus", nx_dbus, succ == 2);
         check("R8", "nx_read", nx_read, !(succ == 2 && ex_store));
         check("R8", "nx_word", nx_word, !(succ == 2 && ex_byte));
         check("R7", "dc_annul", dc_annul, m_dca);
         check("R7", "ex_annul", ex_annul, m_exa);
         check("R9", "ins_int", ins_int, ins);
         check("R10", "ret_hold", ret_hold, m_hold);
         nacc = mem_rdy ? succ : m_acc;
         @(posedge clk);
         if (m_acc == 1 && mem_rdy) m_dmap = 1'b0;
         else if (dma_req) m_dmap = 1'b1;
         if (ins) m_intp = 1'b0;
         else if (irq_req) m_intp = 1'b1;
         if (pe) begin
            m_exa  = take || m_dca;
            m_dca  = take;
            m_hold = ins;
         end
         m_acc = nacc;
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule